// File: doc/BRIEF.md
# Triplicated Strap Majority Reader

This block supplies a read-only 32-bit strap word that is rebuilt from fuse storage. The fuse array keeps three redundant copies of the word in its first twelve bytes. After reset, the block reads those bytes one at a time through a synchronous byte-read port. It assembles each copy with the lower byte address as the least significant byte. It then presents the per-bit two-of-three majority of the three copies as the strap register, and raises a valid flag.

Software reads the voted word at a fixed register offset. Until the fetch completes, reads return zero. Writes to the strap offset are dropped. The surrounding logic can pulse a refresh request to fetch the copies again, for example after the fuse contents change. A refresh that arrives while a fetch is still running is ignored.

Top module: `strap_vote_reader`

## Requirements
- R1: While `rst` is high, `strap_valid` and `arr_rd_en` are 0, and `reg_rd_data` is 0 for any read address.
- R2: After reset is released, the block asserts `arr_rd_en` on exactly 12 consecutive clock edges, with addresses COPY_BASE+0 up to COPY_BASE+11 in ascending order. `strap_valid` is 0 for the first 12 edges after release and 1 after the 13th. Read data is taken one edge after its address.
- R3: Copy k (k = 0, 1, 2) is built from array bytes COPY_BASE+4k to COPY_BASE+4k+3. The byte at the lowest address forms bits 7:0 and the byte at the highest address forms bits 31:24.
- R4: Each bit of the voted word is 1 exactly when that bit is 1 in at least two of the three copies.
- R5: A copy that differs from the other two, in one bit or in many bits, does not change the voted word. The voted word equals the two copies that agree.
- R6: A write of any data to the strap offset, or to any other offset, leaves the value read at the strap offset unchanged.
- R7: With `strap_valid` high, a read at offset STRAP_OFF (default 0x010) returns the voted word. A read at any other offset returns 0.
- R8: A `refresh_req` sampled high while `strap_valid` is 1 clears `strap_valid` on that edge and starts a new 12-byte fetch that picks up the current array contents. A `refresh_req` sampled during a fetch has no effect: that fetch still issues exactly 12 reads.
- R9: While `strap_valid` is 0, a read at the strap offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| refresh_req | input | 1 | Request to fetch the copies again (taken when idle) |
| arr_rd_en | output | 1 | Byte read strobe to the fuse array |
| arr_rd_addr | output | ARR_AW | Byte address to the fuse array |
| arr_rd_data | input | 8 | Byte returned one cycle after the strobe |
| reg_rd_addr | input | REG_AW | Register read offset |
| reg_rd_data | output | WORD_W | Register read data (combinational) |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | REG_AW | Register write offset |
| reg_wr_data | input | WORD_W | Register write data (discarded) |
| strap_valid | output | 1 | Voted word is ready |

## Verification
The bench builds the block with WORD_W=32, COPY_BASE=0 and ARR_AW=4. This gives a sixteen-byte array model, so every fetch address can be recorded and checked against the ascending twelve-byte window. The default STRAP_OFF of 0x010 keeps the strap offset next to other offsets, so the bench can show that neighbouring offsets read zero. Because the word is 32 bits wide, each table vector exercises the byte order and the per-bit vote across all four byte lanes. The vectors include single-bit flips in one copy and whole-word disagreement.

// File: rtl/strap_pkg.sv
package strap_pkg;

    // Fixed redundancy: a two-of-three vote needs exactly three copies.
    localparam int unsigned NUM_COPIES = 3;
    localparam int unsigned BYTE_W     = 8;

    typedef enum logic [1:0] {
        SEQ_FETCH = 2'd0,   // issuing byte reads
        SEQ_DRAIN = 2'd1,   // last byte in flight
        SEQ_DONE  = 2'd2    // copies complete, vote valid
    } seq_state_e;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/strap_fetch_seq.sv
module strap_fetch_seq
    import strap_pkg::*;
#(
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned ARR_AW    = 10,
    parameter int unsigned COPY_BASE = 0,
    localparam int unsigned BYTES    = WORD_W / BYTE_W,
    localparam int unsigned TOTAL    = NUM_COPIES * BYTES,
    localparam int unsigned IDX_W    = $clog2(TOTAL)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              refresh_req,
    output logic              rd_en,
    output logic [ARR_AW-1:0] rd_addr,
    output logic              cap_stb,
    output logic [IDX_W-1:0]  cap_idx,
    output logic              done
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL - 1);

    seq_state_e       state_q;
    logic [IDX_W-1:0] issue_idx_q;
    logic             cap_stb_q;
    logic [IDX_W-1:0] cap_idx_q;

    assign rd_en   = (state_q == SEQ_FETCH) && !rst;
    assign rd_addr = ARR_AW'(COPY_BASE) + ARR_AW'(issue_idx_q);
    assign cap_stb = cap_stb_q;
    assign cap_idx = cap_idx_q;
    assign done    = (state_q == SEQ_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= SEQ_FETCH;
            issue_idx_q <= '0;
            cap_stb_q   <= 1'b0;
            cap_idx_q   <= '0;
        end else begin
            // synchronous array: data for this edge's address arrives next edge
            cap_stb_q <= rd_en;
            cap_idx_q <= issue_idx_q;
            unique case (state_q)
                SEQ_FETCH: begin
                    if (issue_idx_q == LAST_IDX) begin
                        issue_idx_q <= '0;
                        state_q     <= SEQ_DRAIN;
                    end else begin
                        issue_idx_q <= issue_idx_q + 1'b1;
                    end
                end
                SEQ_DRAIN: state_q <= SEQ_DONE;
                SEQ_DONE: begin
                    if (refresh_req) begin
                        state_q     <= SEQ_FETCH;
                        issue_idx_q <= '0;
                    end
                end
                default: state_q <= SEQ_FETCH;
            endcase
        end
    end

    // R2: reads never leave the twelve-byte copy window
    p_addr_in_window_r2: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (rd_addr >= ARR_AW'(COPY_BASE)) &&
                  (rd_addr <= ARR_AW'(COPY_BASE + TOTAL - 1)));

    // R2: back-to-back reads walk upward by one byte
    p_addr_step_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + 1'b1));

    // R2: completion follows the capture of the final byte
    p_done_after_last_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(cap_stb) && ($past(cap_idx) == LAST_IDX)));

endmodule

// File: rtl/strap_copy_store.sv
module strap_copy_store
    import strap_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    localparam int unsigned BYTES = WORD_W / BYTE_W,
    localparam int unsigned TOTAL = NUM_COPIES * BYTES,
    localparam int unsigned IDX_W = $clog2(TOTAL)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_stb,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [BYTE_W-1:0]            wr_byte,
    output logic [NUM_COPIES*WORD_W-1:0] copies
);

    logic [NUM_COPIES*WORD_W-1:0] copies_q;

    assign copies = copies_q;

    // byte index c*BYTES+l lands in copy c, lane l (little-endian)
    for (genvar c = 0; c < NUM_COPIES; c++) begin : g_copy
        for (genvar l = 0; l < BYTES; l++) begin : g_lane
            localparam int unsigned POS = c * BYTES + l;
            localparam int unsigned LSB = c * WORD_W + l * BYTE_W;
            logic hit;
            assign hit = wr_stb && (wr_idx == IDX_W'(POS));
            always_ff @(posedge clk) begin
                if (rst) begin
                    copies_q[LSB +: BYTE_W] <= '0;
                end else if (hit) begin
                    copies_q[LSB +: BYTE_W] <= wr_byte;
                end
            end
        end
    end

    // R3: only the addressed byte lane moves on a capture
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> $stable(copies_q));

endmodule

// File: rtl/strap_vote.sv
module strap_vote
    import strap_pkg::*;
#(
    parameter int unsigned WORD_W = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_COPIES*WORD_W-1:0] copies,
    output logic [WORD_W-1:0]            voted
);

    logic [WORD_W-1:0] cpy_a, cpy_b, cpy_c;

    assign cpy_a = copies[0*WORD_W +: WORD_W];
    assign cpy_b = copies[1*WORD_W +: WORD_W];
    assign cpy_c = copies[2*WORD_W +: WORD_W];

    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
        assign voted[i] = maj3(cpy_a[i], cpy_b[i], cpy_c[i]);
    end

    // R5: any two matching copies outvote the third
    p_two_agree_r5: assert property (@(posedge clk) disable iff (rst)
        ((cpy_a == cpy_b) || (cpy_a == cpy_c)) |-> (voted == cpy_a));

    p_pair_bc_r4: assert property (@(posedge clk) disable iff (rst)
        (cpy_b == cpy_c) |-> (voted == cpy_b));

endmodule

// File: rtl/strap_vote_reader.sv
module strap_vote_reader
    import strap_pkg::*;
#(
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned ARR_AW    = 10,
    parameter int unsigned REG_AW    = 12,
    parameter int unsigned COPY_BASE = 0,
    parameter int unsigned STRAP_OFF = 'h010,
    localparam int unsigned BYTES    = WORD_W / BYTE_W,
    localparam int unsigned TOTAL    = NUM_COPIES * BYTES,
    localparam int unsigned IDX_W    = $clog2(TOTAL)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              refresh_req,
    output logic              arr_rd_en,
    output logic [ARR_AW-1:0] arr_rd_addr,
    input  logic [7:0]        arr_rd_data,
    input  logic [REG_AW-1:0] reg_rd_addr,
    output logic [WORD_W-1:0] reg_rd_data,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_wr_addr,
    input  logic [WORD_W-1:0] reg_wr_data,
    output logic              strap_valid
);

    logic                         cap_stb;
    logic [IDX_W-1:0]             cap_idx;
    logic                         fetch_done;
    logic [NUM_COPIES*WORD_W-1:0] copies;
    logic [WORD_W-1:0]            voted;

    strap_fetch_seq #(
        .WORD_W   (WORD_W),
        .ARR_AW   (ARR_AW),
        .COPY_BASE(COPY_BASE)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .refresh_req(refresh_req),
        .rd_en      (arr_rd_en),
        .rd_addr    (arr_rd_addr),
        .cap_stb    (cap_stb),
        .cap_idx    (cap_idx),
        .done       (fetch_done)
    );

    strap_copy_store #(
        .WORD_W(WORD_W)
    ) u_store (
        .clk    (clk),
        .rst    (rst),
        .wr_stb (cap_stb),
        .wr_idx (cap_idx),
        .wr_byte(arr_rd_data),
        .copies (copies)
    );

    strap_vote #(
        .WORD_W(WORD_W)
    ) u_vote (
        .clk   (clk),
        .rst   (rst),
        .copies(copies),
        .voted (voted)
    );

    assign strap_valid = fetch_done;
    // the register file holds no writable state: writes are dropped here
    assign reg_rd_data = (fetch_done && (reg_rd_addr == REG_AW'(STRAP_OFF))) ? voted : '0;

    // R6: a write carrying a different value leaves the voted word unchanged
    p_wr_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && (reg_wr_addr == REG_AW'(STRAP_OFF)) && (reg_wr_data != voted) &&
         fetch_done && !refresh_req) |=> $stable(voted));

    // R8: an accepted refresh drops the valid flag
    p_refresh_clears_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(fetch_done) && $past(refresh_req)) |-> !strap_valid);

    // R2: no array traffic once the copies are complete
    p_quiet_when_valid_r2: assert property (@(posedge clk) disable iff (rst)
        strap_valid |-> !arr_rd_en);

endmodule

// File: tb/tb_strap_vote_reader.sv
module tb_strap_vote_reader;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned ARR_AW = 4;
    localparam int unsigned REG_AW = 12;
    localparam logic [REG_AW-1:0] OFF = 12'h010;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              refresh_req = 1'b0;
    logic              arr_rd_en;
    logic [ARR_AW-1:0] arr_rd_addr;
    logic [7:0]        arr_rd_data;
    logic [REG_AW-1:0] reg_rd_addr = '0;
    logic [WORD_W-1:0] reg_rd_data;
    logic              reg_wr_en = 1'b0;
    logic [REG_AW-1:0] reg_wr_addr = '0;
    logic [WORD_W-1:0] reg_wr_data = '0;
    logic              strap_valid;

    always #2 clk = ~clk;

    strap_vote_reader #(
        .WORD_W(WORD_W), .ARR_AW(ARR_AW), .REG_AW(REG_AW),
        .COPY_BASE(0), .STRAP_OFF('h010)
    ) dut (
        .clk(clk), .rst(rst), .refresh_req(refresh_req),
        .arr_rd_en(arr_rd_en), .arr_rd_addr(arr_rd_addr), .arr_rd_data(arr_rd_data),
        .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .strap_valid(strap_valid)
    );

    // fuse array model with a synchronous read port
    logic [7:0] mem [16];
    initial arr_rd_data = 8'h00;
    always @(posedge clk) if (arr_rd_en) arr_rd_data <= mem[arr_rd_addr];

    // fetch monitor: counts reads and checks ascending order
    int rd_count = 0;
    int addr_err = 0;
    int next_addr = 0;
    always @(posedge clk) begin
        if (!rst && arr_rd_en) begin
            if (int'(arr_rd_addr) != next_addr) addr_err++;
            next_addr++;
            rd_count++;
        end
    end

    int nchk = 0;
    int nfail = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clr_mon();
        rd_count = 0; addr_err = 0; next_addr = 0;
    endtask

    task automatic put_word(input int k, input logic [31:0] w);
        for (int b = 0; b < 4; b++) mem[4*k + b] = w[8*b +: 8];
    endtask

    task automatic rd(input logic [REG_AW-1:0] a, output logic [31:0] d);
        reg_rd_addr = a;
        #1;
        d = reg_rd_data;
    endtask

    task automatic wait_valid(input string req);
        int n = 0;
        while (!strap_valid && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk(req, {31'd0, strap_valid}, 32'd1);
    endtask

    task automatic do_refresh();
        @(negedge clk);
        refresh_req = 1'b1;
        @(negedge clk);
        refresh_req = 1'b0;
    endtask

    // copy0, copy1, copy2, expected vote
    localparam logic [127:0] VEC [6] = '{
        {32'hA5A51234, 32'hA5A51234, 32'hA5A51234, 32'hA5A51234},
        {32'hFFFF0000, 32'h0000FFFF, 32'hFF00FF00, 32'hFF00FF00},
        {32'h12345678, 32'h12345678, 32'h12345679, 32'h12345678},
        {32'h00000000, 32'hFFFFFFFF, 32'h00000000, 32'h00000000},
        {32'h80000001, 32'h80000000, 32'h00000001, 32'h80000001},
        {32'hDEADBEEF, 32'hDEACBEEF, 32'hDEADBEEF, 32'hDEADBEEF}
    };

    initial begin
        #800000;
        nfail++;
        $display("FAIL watchdog R2 actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        for (int i = 0; i < 16; i++) mem[i] = 8'h00;
        // R3 byte order: copy0 and copy1 are bytes 04 03 02 01 -> 01020304
        put_word(0, 32'h01020304);
        put_word(1, 32'h01020304);
        put_word(2, 32'h0A0B0C0D);

        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 valid", {31'd0, strap_valid}, 32'd0);
        chk("R1 rd_en", {31'd0, arr_rd_en}, 32'd0);
        rd(OFF, d);
        chk("R1 read", d, 32'd0);

        clr_mon();
        rst = 1'b0;
        repeat (12) @(negedge clk);
        // R2/R9: still fetching after 12 edges, reads return zero
        chk("R2 valid low at 12", {31'd0, strap_valid}, 32'd0);
        rd(OFF, d);
        chk("R9 read before valid", d, 32'd0);
        @(negedge clk);
        chk("R2 valid at 13", {31'd0, strap_valid}, 32'd1);
        chk("R2 read count", rd_count, 32'd12);
        chk("R2 addr order", addr_err, 32'd0);
        rd(OFF, d);
        chk("R3 little-endian copies", d, 32'h01020304);
        rd(12'h00C, d);
        chk("R7 other offset", d, 32'd0);
        rd(12'h014, d);
        chk("R7 other offset high", d, 32'd0);

        // R6: writes to strap and other offsets
        reg_wr_en = 1'b1; reg_wr_addr = OFF; reg_wr_data = 32'hFFFFFFFF;
        @(negedge clk);
        reg_wr_addr = 12'h000; reg_wr_data = 32'h00000000;
        @(negedge clk);
        reg_wr_en = 1'b0;
        rd(OFF, d);
        chk("R6 write ignored", d, 32'h01020304);

        // R4/R5: vector table
        foreach (VEC[i]) begin
            put_word(0, VEC[i][127:96]);
            put_word(1, VEC[i][95:64]);
            put_word(2, VEC[i][63:32]);
            clr_mon();
            do_refresh();
            // R8/R9: accepted refresh cleared valid
            chk("R8 valid cleared", {31'd0, strap_valid}, 32'd0);
            rd(OFF, d);
            chk("R9 read during refetch", d, 32'd0);
            wait_valid("R8 refetch completes");
            chk("R8 refetch count", rd_count, 32'd12);
            rd(OFF, d);
            chk((i == 2 || i == 5) ? "R5 single corrupt copy" : "R4 majority", d, VEC[i][31:0]);
        end

        // R8: refresh during a fetch is ignored
        put_word(0, 32'h55AA00FF);
        put_word(1, 32'h55AA00FF);
        put_word(2, 32'h00000000);
        clr_mon();
        do_refresh();
        repeat (2) @(negedge clk);
        do_refresh();
        wait_valid("R8 completes after mid refresh");
        repeat (4) @(negedge clk);
        chk("R8 mid-fetch refresh ignored", rd_count, 32'd12);
        chk("R2 order after refresh", addr_err, 32'd0);
        rd(OFF, d);
        chk("R4 after mid refresh", d, 32'h55AA00FF);

        // R1: reset again drops valid
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 reset clears valid", {31'd0, strap_valid}, 32'd0);
        rd(OFF, d);
        chk("R1 reset read", d, 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule